// File: doc/BRIEF.md
# Strobed Serial PCM Port

This block moves one 8-bit PCM sample in each direction per frame over a strobed synchronous serial link. An external active-high strobe, aligned with the bit clock and eight bit-clock cycles long, marks the only timeslot of the frame. While it is high the port shifts the transmit byte out, most significant bit first, and shifts a receive byte in. Outside that window the serial output is not driven. The bit clock may run anywhere from 128 kHz to 4096 kHz and is treated as synchronous. The port oversamples the bit clock, the strobe and the serial input with a fast system clock.

The control inputs can replace either direction's byte with the quiet code, the negative-zero value of the selected companding law and coding. The transmit side also sends the quiet code when the audio path is powered down and a strobe still arrives. In that case the output stays driven, not floating. A received byte appears on the parallel side, with a one-cycle valid pulse, inside the same strobe window in which it arrived. There is no frame of delay.

Top module: `strobed_pcm_port`

## Requirements
- R1: After reset, `sdout_oe` is 0, `rx_valid` is 0 and `rx_byte` is 0x00.
- R2: `sdout_oe` is 1 only during a strobe window. It is 0 between windows and for whole frames in which no strobe appears.
- R3: The transmit byte is sent MSB first. A new bit is driven after each rising bit-clock edge in the window. `tx_byte` is captured at the first rising edge of the window, so a change during the transfer is not sent until the next frame.
- R4: `sdin` is sampled MSB first on the falling bit-clock edges of the window. After the eighth falling edge, `rx_byte` is updated and `rx_valid` pulses for exactly one `clk` cycle while the window is still open.
- R5: With `tx_mute` = 1 at the first rising edge of the window, the quiet code is sent instead of `tx_byte`.
- R6: With `path_pd` = 1, a valid strobe still enables the output, and the port sends the quiet code during the window.
- R7: With `rx_mute` = 1 when the eighth bit arrives, `rx_byte` takes the quiet code instead of the received bits. `rx_valid` still pulses.
- R8: The quiet code depends on two inputs. With `code_smag` = 0 and `law_a` = 0 (mu-law) it is 0x7F. With `code_smag` = 0 and `law_a` = 1 (A-law) it is 0x55. With `code_smag` = 1 it is 0x00 for either law.
- R9: A window that closes before eight bits produces no `rx_valid`. The next window starts again from its first bit in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial link |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| strobe | input | 1 | Active-high timeslot strobe, eight bit clocks long |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| sdout_oe | output | 1 | Output enable for `sdout` (0 = high impedance) |
| tx_byte | input | 8 | Parallel PCM byte to transmit |
| rx_byte | output | 8 | Last received PCM byte (or quiet code) |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is updated |
| tx_mute | input | 1 | Send quiet code instead of `tx_byte` |
| rx_mute | input | 1 | Deliver quiet code instead of received byte |
| path_pd | input | 1 | Audio path powered down; transmit quiet code |
| law_a | input | 1 | 1 = A-law, 0 = mu-law |
| code_smag | input | 1 | 1 = sign-magnitude coding, 0 = ITU coding |

## Verification
The assertions check four properties on every cycle:
- the output enable falls once the synchronised strobe is low;
- `rx_valid` never lasts longer than one cycle;
- every received byte is delivered while the output window is still open;
- a muted receive byte equals the quiet code for the law and coding in force.

Only the bench scenarios can show the remaining behaviour:
- the MSB-first bit order in both directions;
- the capture of `tx_byte` at the first edge when it changes mid-transfer;
- the transmit substitution under mute and power-down for each law and coding;
- the recovery after a window that closes early.

// File: rtl/pcm_port_pkg.sv
// Package: shared widths and the quiet-code selection for the strobed PCM port.
package pcm_port_pkg;

    localparam int PCM_BITS = 8;

    typedef logic [PCM_BITS-1:0] pcm_t;

    // Negative-zero code for the selected law and coding
    function automatic pcm_t quiet_code(input logic law_a, input logic smag);
        pcm_t q;
        if (smag)       q = 8'h00;
        else if (law_a) q = 8'h55;
        else            q = 8'h7F;
        return q;
    endfunction

endpackage

// File: rtl/pcm_in_sync.sv
// Module: pcm_in_sync
// Brings a group of asynchronous single-bit inputs into the clk domain
// through STAGES flops each. All bits see the same latency, so inputs that
// change together on the link stay aligned after synchronisation.
module pcm_in_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] pipe [STAGES];

    // Shift each input through its synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= d_async;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign d_sync = pipe[STAGES-1];
endmodule

// File: rtl/pcm_edge_det.sv
// Module: pcm_edge_det
// Turns the synchronised bit clock into single-cycle rise and fall strobes.
// Assumes the bit clock is much slower than clk, so each level lasts at
// least two clk cycles.
module pcm_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic level_q;

    // Remember the previous level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
    assign fall = ~level & level_q;
endmodule

// File: rtl/pcm_tx_shift.sv
// Module: pcm_tx_shift
// Transmit serialiser. At the first rising bit-clock edge of a window it
// captures either the parallel byte or the quiet code, then drives one bit
// per rising edge, MSB first. Outside the window the enable is low and the
// data line is held at 0. Surplus edges of an over-long window repeat the
// last bit.
module pcm_tx_shift
    import pcm_port_pkg::*;
#(
    parameter int BITS = PCM_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise,
    input  logic            win,
    input  logic [BITS-1:0] par_in,
    input  logic            subst,
    input  logic [BITS-1:0] quiet,
    output logic            sd_out,
    output logic            sd_oe
);
    localparam int CW = $clog2(BITS + 1);

    logic [BITS-1:0] sr;
    logic [CW-1:0]   cnt;
    logic [BITS-1:0] src;

    // Choose what the window will carry
    always_comb src = subst ? quiet : par_in;

    // Load, shift and count the transmit bits within a window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '0;
            cnt    <= '0;
            sd_out <= 1'b0;
        end else if (!win) begin
            cnt    <= '0;
            sd_out <= 1'b0;
        end else if (rise) begin
            if (cnt == '0) begin
                sd_out <= src[BITS-1];
                sr     <= src << 1;
                cnt    <= CW'(1);
            end else if (cnt < CW'(BITS)) begin
                sd_out <= sr[BITS-1];
                sr     <= sr << 1;
                cnt    <= cnt + CW'(1);
            end
        end
    end

    // Output enable follows the synchronised window
    always_ff @(posedge clk) begin
        if (!rst_n) sd_oe <= 1'b0;
        else        sd_oe <= win;
    end
endmodule

// File: rtl/pcm_rx_shift.sv
// Module: pcm_rx_shift
// Receive deserialiser. It samples the serial input on each falling
// bit-clock edge of a window, MSB first. On the final bit it publishes the
// byte, or the quiet code when muted, with a one-cycle valid pulse. A window
// that closes early clears the bit count and publishes nothing.
module pcm_rx_shift
    import pcm_port_pkg::*;
#(
    parameter int BITS = PCM_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fall,
    input  logic            win,
    input  logic            sd_in,
    input  logic            mute,
    input  logic [BITS-1:0] quiet,
    output logic [BITS-1:0] par_out,
    output logic            valid
);
    localparam int CW = $clog2(BITS + 1);

    logic [BITS-2:0] sr;
    logic [CW-1:0]   cnt;

    // Collect bits and publish a completed byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr      <= '0;
            cnt     <= '0;
            par_out <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (!win) begin
                cnt <= '0;
            end else if (fall && cnt < CW'(BITS)) begin
                sr  <= {sr[BITS-3:0], sd_in};
                cnt <= cnt + CW'(1);
                if (cnt == CW'(BITS - 1)) begin
                    par_out <= mute ? quiet : {sr, sd_in};
                    valid   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/strobed_pcm_port.sv
// Module: strobed_pcm_port (top)
// Strobed serial PCM port for one 8-bit timeslot per frame. The bit clock,
// the strobe and the serial input are oversampled by clk. They go through a
// shared synchroniser so that they stay aligned. Assumes a synchronous bit
// clock at least about 8x slower than clk, and a strobe that changes with
// rising bit-clock edges.
module strobed_pcm_port
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bclk,
    input  logic       strobe,
    input  logic       sdin,
    output logic       sdout,
    output logic       sdout_oe,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    input  logic       tx_mute,
    input  logic       rx_mute,
    input  logic       path_pd,
    input  logic       law_a,
    input  logic       code_smag
);
    localparam int SYNC_STAGES = 2;

    logic [2:0] link_sync;
    logic       bclk_s, strobe_s, sdin_s;
    logic       bclk_rise, bclk_fall;
    pcm_t       quiet;

    pcm_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({bclk, strobe, sdin}),
        .d_sync (link_sync)
    );

    assign {bclk_s, strobe_s, sdin_s} = link_sync;

    pcm_edge_det u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(bclk_s),
        .rise (bclk_rise),
        .fall (bclk_fall)
    );

    // Quiet code for the law and coding currently selected
    always_comb quiet = quiet_code(law_a, code_smag);

    pcm_tx_shift #(.BITS(PCM_BITS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (bclk_rise),
        .win   (strobe_s),
        .par_in(tx_byte),
        .subst (tx_mute | path_pd),
        .quiet (quiet),
        .sd_out(sdout),
        .sd_oe (sdout_oe)
    );

    pcm_rx_shift #(.BITS(PCM_BITS)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall   (bclk_fall),
        .win    (strobe_s),
        .sd_in  (sdin_s),
        .mute   (rx_mute),
        .quiet  (quiet),
        .par_out(rx_byte),
        .valid  (rx_valid)
    );
endmodule

// File: rtl/pcm_port_chk.sv
// Module: pcm_port_chk
// Property checker for strobed_pcm_port, bound to the top module.
module pcm_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       strobe_s,
    input logic       sdout_oe,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       rx_mute,
    input logic       law_a,
    input logic       code_smag
);
    // R2
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_s |=> !sdout_oe);

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R4
    no_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> sdout_oe);

    // R7
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(rx_mute) && $past(code_smag) == code_smag
                  && $past(law_a) == law_a)
        |-> rx_byte == (code_smag ? 8'h00 : (law_a ? 8'h55 : 8'h7F)));
endmodule

bind strobed_pcm_port pcm_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_s (strobe_s),
    .sdout_oe (sdout_oe),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_mute  (rx_mute),
    .law_a    (law_a),
    .code_smag(code_smag)
);

// File: tb/sim_strobed_pcm_port.sv
// Scoreboard bench for strobed_pcm_port.
module sim_strobed_pcm_port;
    localparam int HALF = 40;   // clk cycles per bit-clock half period

    logic clk = 1'b0, rst_n = 1'b0;
    logic bclk = 1'b0, strobe = 1'b0, sdin = 1'b0;
    logic sdout, sdout_oe, rx_valid;
    logic [7:0] tx_byte = 8'h00, rx_byte;
    logic tx_mute = 0, rx_mute = 0, path_pd = 0, law_a = 0, code_smag = 0;

    int checks = 0, fails = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    logic [7:0] tx_name[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    strobed_pcm_port u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] qc();
        return code_smag ? 8'h00 : (law_a ? 8'h55 : 8'h7F);
    endfunction

    task automatic bit_cycle(input logic stb, input logic d);
        @(posedge clk); #1;
        bclk = 1'b1; strobe = stb; sdin = d;
        repeat (HALF) @(posedge clk);
        #1 bclk = 1'b0;
        repeat (HALF - 1) @(posedge clk);
    endtask

    // Driver: one frame, pushing expected items into the scoreboard
    task automatic frame(input logic [7:0] txv, input logic [7:0] rxv,
                         input int nbits, input bit midchg);
        tx_byte = txv;
        if (nbits == 8) begin
            tx_q.push_back((tx_mute | path_pd) ? qc() : txv);
            rx_q.push_back(rx_mute ? qc() : rxv);
        end
        for (int i = 0; i < nbits; i++) begin
            bit_cycle(1'b1, rxv[7-i]);
            if (midchg && i == 2) tx_byte = ~txv;
        end
        for (int i = 0; i < 4; i++) bit_cycle(1'b0, 1'b0);
    endtask

    // Monitor: transmit bits and output enable at each falling bit-clock edge
    initial begin
        logic [7:0] acc;
        int n;
        n = 0; acc = 0;
        forever begin
            @(negedge bclk);
            chk(sdout_oe == strobe, "R2 oe", sdout_oe, strobe);
            if (sdout_oe) begin
                acc = {acc[6:0], sdout};
                n++;
                if (n == 8) begin
                    if (tx_q.size() == 0) chk(0, "R9 unexpected tx byte", acc, 0);
                    else begin
                        logic [7:0] e;
                        e = tx_q.pop_front();
                        chk(acc == e, "R3/R5/R6/R8 tx byte", acc, e);
                    end
                end
            end else n = 0;
        end
    end

    // Monitor: received bytes
    initial begin
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                chk(strobe == 1'b1, "R4 no frame delay", strobe, 1);
                if (rx_q.size() == 0) chk(0, "R9 unexpected rx_valid", rx_byte, 0);
                else begin
                    logic [7:0] e;
                    e = rx_q.pop_front();
                    chk(rx_byte == e, "R4/R7/R8 rx byte", rx_byte, e);
                end
            end
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sdout_oe == 0, "R1 oe", sdout_oe, 0);
        chk(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
        chk(rx_byte == 0, "R1 rx_byte", rx_byte, 0);
        for (int i = 0; i < 2; i++) bit_cycle(1'b0, 1'b0);
        frame(8'hA5, 8'h3C, 8, 0);                      // R3 R4 basic
        frame(8'h01, 8'h80, 8, 1);                      // R3 mid-frame change
        tx_mute = 1; frame(8'hC6, 8'h5A, 8, 0);         // R5 mu-law 0x7F
        tx_mute = 0; path_pd = 1; law_a = 1; rx_mute = 1;
        frame(8'h12, 8'hE7, 8, 0);                      // R6 R7 A-law 0x55
        path_pd = 0; tx_mute = 1; code_smag = 1;
        frame(8'h34, 8'h99, 8, 0);                      // R8 sign-magnitude 0x00
        tx_mute = 0; rx_mute = 0; code_smag = 0; law_a = 0;
        for (int i = 0; i < 12; i++) bit_cycle(1'b0, 1'b1); // R2 frame with no strobe
        frame(8'hF0, 8'h0F, 5, 0);                      // R9 short window
        frame(8'hC3, 8'h96, 8, 0);                      // R9 fresh start
        rx_mute = 1; frame(8'h5A, 8'h44, 8, 0);         // R7 mu-law 0x7F
        rx_mute = 0; frame(8'hFF, 8'h00, 8, 0);
        repeat (20) @(posedge clk);
        chk(tx_q.size() == 0, "R3 tx scoreboard drained", tx_q.size(), 0);
        chk(rx_q.size() == 0, "R4 rx scoreboard drained", rx_q.size(), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                chk(0, "watchdog", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule